// File: doc/BRIEF.md
# Descriptor Ring Master Controller

The block walks a circular ring of bus-transaction descriptors that are kept in a local descriptor store. Software fills one or more 16-byte descriptors through a word-addressed window. It then moves its producer index (the head) to the slot just past the last filled entry and sets the run bit. The controller owns the consumer index (the tail). While the run bit is set and the tail has not caught up with the head, it hands the descriptor at the tail to an external transaction sequencer over a request/done handshake. When the sequencer finishes, the controller stores the outcome status and the byte counts back into the descriptor and moves the tail forward, wrapping after the last slot of the programmed ring size.

Completion and fault events are latched into two status flags that software clears by writing a one to them. They drive a single interrupt line. A descriptor can ask for a completion flag when it finishes. It can also ask the controller to halt the ring when it finishes with a fault.

Top module: `dring_master`

## Requirements
- R1: After reset the control register, status register and both base-address words read 0, the size register reads DEPTH-1, and seq_req and irq are 0.
- R2: Register word offsets 0 and 1 (reg_addr MSB clear) hold the low and high 32-bit halves of the ring base address. Both are fully writable and read back unchanged.
- R3: With reg_addr MSB set, reg_addr[IDX_W+1:0] selects word {entry, word-in-descriptor} of the descriptor store for 32-bit reads and writes. Word 0 is {control[31:24], read length[23:16], write length or command[15:8], target address and R/W[7:0]}. Word 1 is {sent count[31:24], received count[23:16], retry[15:8], status[7:0]}. Words 2 and 3 are the low and high data pointer.
- R4: The control register (offset 2) holds run at bit 0, error-interrupt enable at bit 4 and the head in bits 16 and up. When run is 1 and tail differs from head, seq_req rises one cycle later and stays high while descriptors remain. The descriptor at the tail is presented on the seq_* outputs, and status bit 0 reads 1 while seq_req is high.
- R5: A cycle with seq_req and seq_done both high writes word 1 of the current descriptor as {seq_tx_cnt, seq_rx_cnt, unchanged retry byte, seq_status} and advances the tail. seq_req falls once the advanced tail equals the head. Status bits 16 and up read the tail.
- R6: The size register (offset 4) holds the entry count minus one in its low IDX_W bits; upper written bits are dropped. After the slot equal to that value, the tail wraps to 0.
- R7: Completing a descriptor whose word-0 bit 30 is set raises the completion flag at status bit 5.
- R8: Writing 1 to status bit 4 or bit 5 clears that flag. Writing 0 leaves it unchanged.
- R9: A descriptor that completes with any of status bits 7:2 set and with word-0 bit 31 set clears run, raises the error flag at status bit 4, and stops the ring after its write-back. Without bit 31 the fault neither stops the ring nor raises the flag.
- R10: irq is high when the completion flag is set, or when the error flag and the error-interrupt enable are both set.
- R11: Clearing run while a descriptor is in flight lets that descriptor finish. No further descriptor is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register or descriptor-window write strobe |
| reg_addr | input | ADDR_W | Word address; MSB selects the descriptor window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| seq_req | output | 1 | Descriptor at the tail awaits execution |
| seq_target | output | 8 | Target address and R/W bit of the current descriptor |
| seq_wr_len | output | 8 | Write length or command byte |
| seq_rd_len | output | 8 | Read length |
| seq_ctrl | output | 8 | Control byte |
| seq_dptr | output | 64 | Data pointer |
| seq_done | input | 1 | Sequencer finished the current descriptor |
| seq_status | input | 8 | Outcome status byte |
| seq_rx_cnt | input | 8 | Bytes received |
| seq_tx_cnt | input | 8 | Bytes sent |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted tail shows up within a cycle as the wrong descriptor on the seq_* outputs. It then shows up as a write-back landing in the wrong slot, which a read of the window exposes. A wrong request state shows up as seq_req disagreeing with the run, head and tail relation on the next clock. A flag that is set or cleared in error shows on irq at the same edge. The bench holds a behavioural copy of the ring and compares seq_req, the presented descriptor and irq on every clock. This catches such faults in the cycle they arise, not only at the end of a sequence.

// File: rtl/dring_pkg.sv
package dring_pkg;
   localparam int WORD_W      = 32;
   // register word offsets below the descriptor window
   localparam int OFS_BASE_LO = 0;
   localparam int OFS_BASE_HI = 1;
   localparam int OFS_CTRL    = 2;
   localparam int OFS_STAT    = 3;
   localparam int OFS_SIZE    = 4;
   // bit positions
   localparam int CTRL_RUN    = 0;
   localparam int CTRL_ERRIE  = 4;
   localparam int PTR_LSB     = 16;
   localparam int STAT_BUSY   = 0;
   localparam int STAT_ERR    = 4;
   localparam int STAT_DONE   = 5;
   localparam int CB_IRQ      = 6;   // within the control byte
   localparam int CB_STOP     = 7;

   function automatic logic is_fault(input logic [7:0] st);
      return |st[7:2];
   endfunction
endpackage

// File: rtl/dring_store.sv
module dring_store #(
   parameter int DEPTH = 32,
   parameter int IDX_W = 5
) (
   input  logic                 clk,
   input  logic                 sw_we,
   input  logic [IDX_W+1:0]     sw_loc,
   input  logic [31:0]          sw_wdata,
   output logic [31:0]          sw_rdata,
   input  logic [IDX_W-1:0]     eng_idx,
   input  logic                 hw_we,
   input  logic [31:0]          hw_wdata,
   output logic [31:0]          eng_w0,
   output logic [7:0]           eng_retry,
   output logic [63:0]          eng_dptr
);
   localparam int WORDS = DEPTH * 4;

   logic [31:0] mem [WORDS];
   logic [31:0] w1;

   // engine write-back takes priority over a colliding software write
   always_ff @(posedge clk) begin
      if (sw_we) mem[sw_loc] <= sw_wdata;
      if (hw_we) mem[{eng_idx, 2'd1}] <= hw_wdata;
   end

   assign sw_rdata  = mem[sw_loc];
   assign eng_w0    = mem[{eng_idx, 2'd0}];
   assign w1        = mem[{eng_idx, 2'd1}];
   assign eng_retry = w1[15:8];
   assign eng_dptr  = {mem[{eng_idx, 2'd3}], mem[{eng_idx, 2'd2}]};
endmodule

// File: rtl/dring_engine.sv
module dring_engine
   import dring_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [IDX_W-1:0] head,
   input  logic [IDX_W-1:0] last,
   input  logic [7:0]       ctl_byte,
   input  logic [7:0]       retry_byte,
   input  logic             seq_done,
   input  logic [7:0]       seq_status,
   input  logic [7:0]       seq_rx_cnt,
   input  logic [7:0]       seq_tx_cnt,
   output logic [IDX_W-1:0] tail,
   output logic             active,
   output logic             wb_we,
   output logic [31:0]      wb_data,
   output logic             note_done,
   output logic             halt
);
   logic [IDX_W-1:0] tail_nx;

   always_comb begin
      tail_nx   = (tail == last) ? '0 : tail + IDX_W'(1);
      wb_we     = active & seq_done;
      wb_data   = {seq_tx_cnt, seq_rx_cnt, retry_byte, seq_status};
      halt      = wb_we & ctl_byte[CB_STOP] & is_fault(seq_status);
      note_done = wb_we & ctl_byte[CB_IRQ];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tail   <= '0;
         active <= 1'b0;
      end else if (!active) begin
         active <= run && (tail != head);
      end else if (seq_done) begin
         tail   <= tail_nx;
         active <= run && !halt && (tail_nx != head);
      end
   end

   // R5: the tail only moves on a completion
   a_r5_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(active && seq_done) |=> $stable(tail));
   // R4: no request without run and pending work
   a_r4_idle_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !(run && tail != head)) |=> !active);
   // R9: a halting fault ends the request
   a_r9_halt_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (active && seq_done && ctl_byte[CB_STOP] && (seq_status[7:2] != 6'd0)) |=> !active);
endmodule

// File: rtl/dring_master.sv
module dring_master
   import dring_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              seq_req,
   output logic [7:0]        seq_target,
   output logic [7:0]        seq_wr_len,
   output logic [7:0]        seq_rd_len,
   output logic [7:0]        seq_ctrl,
   output logic [63:0]       seq_dptr,
   input  logic              seq_done,
   input  logic [7:0]        seq_status,
   input  logic [7:0]        seq_rx_cnt,
   input  logic [7:0]        seq_tx_cnt,
   output logic              irq
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int LOC_W = IDX_W + 2;
   localparam int OFS_W = ADDR_W - 1;

   if (DEPTH < 2 || DEPTH > 256 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two between 2 and 256");
   end
   if (OFS_W < LOC_W || OFS_W < 3) begin : g_bad_addr
      $error("ADDR_W too narrow for the descriptor window");
   end

   logic             win, sw_we, ctl_wr, stat_wr;
   logic [31:0]      base_lo, base_hi, sw_rdata, w0, wb_data;
   logic             run, err_ie, done_f, err_f;
   logic [IDX_W-1:0] head, last, tail;
   logic             active, wb_we, note_done, halt;
   logic [7:0]       retry_byte;

   assign win     = reg_addr[ADDR_W-1];
   assign sw_we   = reg_we & win;
   assign ctl_wr  = reg_we & !win & (reg_addr[OFS_W-1:0] == OFS_W'(OFS_CTRL));
   assign stat_wr = reg_we & !win & (reg_addr[OFS_W-1:0] == OFS_W'(OFS_STAT));

   dring_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .sw_we     (sw_we),
      .sw_loc    (reg_addr[LOC_W-1:0]),
      .sw_wdata  (reg_wdata),
      .sw_rdata  (sw_rdata),
      .eng_idx   (tail),
      .hw_we     (wb_we),
      .hw_wdata  (wb_data),
      .eng_w0    (w0),
      .eng_retry (retry_byte),
      .eng_dptr  (seq_dptr)
   );

   assign seq_target = w0[7:0];
   assign seq_wr_len = w0[15:8];
   assign seq_rd_len = w0[23:16];
   assign seq_ctrl   = w0[31:24];
   assign seq_req    = active;

   dring_engine #(.IDX_W(IDX_W)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .head       (head),
      .last       (last),
      .ctl_byte   (seq_ctrl),
      .retry_byte (retry_byte),
      .seq_done   (seq_done),
      .seq_status (seq_status),
      .seq_rx_cnt (seq_rx_cnt),
      .seq_tx_cnt (seq_tx_cnt),
      .tail       (tail),
      .active     (active),
      .wb_we      (wb_we),
      .wb_data    (wb_data),
      .note_done  (note_done),
      .halt       (halt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_lo <= '0;
         base_hi <= '0;
         run     <= 1'b0;
         err_ie  <= 1'b0;
         head    <= '0;
         last    <= IDX_W'(DEPTH - 1);
         done_f  <= 1'b0;
         err_f   <= 1'b0;
      end else begin
         if (reg_we && !win) begin
            if (reg_addr[OFS_W-1:0] == OFS_W'(OFS_BASE_LO)) base_lo <= reg_wdata;
            if (reg_addr[OFS_W-1:0] == OFS_W'(OFS_BASE_HI)) base_hi <= reg_wdata;
            if (reg_addr[OFS_W-1:0] == OFS_W'(OFS_SIZE))    last    <= reg_wdata[IDX_W-1:0];
         end
         if (ctl_wr) begin
            run    <= reg_wdata[CTRL_RUN];
            err_ie <= reg_wdata[CTRL_ERRIE];
            head   <= reg_wdata[PTR_LSB +: IDX_W];
         end
         if (stat_wr && reg_wdata[STAT_ERR])  err_f  <= 1'b0;
         if (stat_wr && reg_wdata[STAT_DONE]) done_f <= 1'b0;
         // hardware events win over a same-cycle software write
         if (halt) begin
            run   <= 1'b0;
            err_f <= 1'b1;
         end
         if (note_done) done_f <= 1'b1;
      end
   end

   assign irq = done_f | (err_f & err_ie);

   always_comb begin
      reg_rdata = '0;
      if (win) begin
         reg_rdata = sw_rdata;
      end else begin
         case (reg_addr[OFS_W-1:0])
            OFS_W'(OFS_BASE_LO): reg_rdata = base_lo;
            OFS_W'(OFS_BASE_HI): reg_rdata = base_hi;
            OFS_W'(OFS_CTRL): begin
               reg_rdata[CTRL_RUN]           = run;
               reg_rdata[CTRL_ERRIE]         = err_ie;
               reg_rdata[PTR_LSB +: IDX_W]   = head;
            end
            OFS_W'(OFS_STAT): begin
               reg_rdata[STAT_BUSY]          = active;
               reg_rdata[STAT_ERR]           = err_f;
               reg_rdata[STAT_DONE]          = done_f;
               reg_rdata[PTR_LSB +: IDX_W]   = tail;
            end
            OFS_W'(OFS_SIZE): reg_rdata[IDX_W-1:0] = last;
            default: reg_rdata = '0;
         endcase
      end
   end

   // R7: the completion flag only rises after a flagged completion
   a_r7_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_f) |-> $past(note_done));
   // R8: write-one clears the completion flag
   a_r8_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && reg_wdata[STAT_DONE] && !note_done) |=> !done_f);
   // R9: a halt drops the run bit
   a_r9_halt_drops_run: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !run);
endmodule

// File: tb/test_dring_master.sv
`timescale 1ns/1ps
module test_dring_master;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        seq_req, irq;
   logic [7:0]  seq_target, seq_wr_len, seq_rd_len, seq_ctrl;
   logic [63:0] seq_dptr;
   logic        seq_done = 1'b0;
   logic [7:0]  seq_status = '0, seq_rx_cnt = '0, seq_tx_cnt = '0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dring_master i_dring_master (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_req(seq_req),
      .seq_target(seq_target), .seq_wr_len(seq_wr_len), .seq_rd_len(seq_rd_len),
      .seq_ctrl(seq_ctrl), .seq_dptr(seq_dptr), .seq_done(seq_done),
      .seq_status(seq_status), .seq_rx_cnt(seq_rx_cnt), .seq_tx_cnt(seq_tx_cnt),
      .irq(irq)
   );

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_ram [128];
   int          m_tail, m_head, m_last;
   bit          m_active, m_run, m_ie, m_done, m_err;
   logic [31:0] mw0, mw1;
   int          mnx, o_head;
   bit          mwb, mhalt, mnd, o_run;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tail = 0; m_head = 0; m_last = 31;
         m_active = 0; m_run = 0; m_ie = 0; m_done = 0; m_err = 0;
      end else begin
         mw0    = m_ram[m_tail*4];
         mw1    = m_ram[m_tail*4+1];
         mwb    = m_active && seq_done;
         mnx    = (m_tail == m_last) ? 0 : m_tail + 1;
         mhalt  = mwb && mw0[31] && (seq_status[7:2] != 0);
         mnd    = mwb && mw0[30];
         o_run  = m_run;
         o_head = m_head;
         if (reg_we) begin
            if (reg_addr >= 8'd128) m_ram[int'(reg_addr) - 128] = reg_wdata;
            else if (reg_addr == 8'd2) begin
               m_run = reg_wdata[0]; m_ie = reg_wdata[4]; m_head = int'(reg_wdata[20:16]);
            end else if (reg_addr == 8'd3) begin
               if (reg_wdata[4]) m_err = 0;
               if (reg_wdata[5]) m_done = 0;
            end else if (reg_addr == 8'd4) m_last = int'(reg_wdata[4:0]);
         end
         if (mwb) m_ram[m_tail*4+1] = {seq_tx_cnt, seq_rx_cnt, mw1[15:8], seq_status};
         if (mhalt) begin m_run = 0; m_err = 1; end
         if (mnd) m_done = 1;
         if (!m_active) m_active = o_run && (m_tail != o_head);
         else if (seq_done) begin
            m_tail   = mnx;
            m_active = o_run && !mhalt && (mnx != o_head);
         end
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(64'(seq_req), 64'(m_active), "R4 seq_req vs model");
         chk(64'(irq), 64'(m_done | (m_err & m_ie)), "R10 irq vs model");
         if (m_active) begin
            chk(64'({seq_ctrl, seq_rd_len, seq_wr_len, seq_target}), 64'(m_ram[m_tail*4]), "R4 descriptor word0 vs model");
            chk(seq_dptr, {m_ram[m_tail*4+3], m_ram[m_tail*4+2]}, "R4 data pointer vs model");
         end
      end
   end

   // transaction sequencer stand-in: status = write-length byte, rx = read length, tx = write length + 1
   int scnt = 0;
   always @(negedge clk) begin
      if (!rst_n || seq_done) begin
         seq_done = 1'b0;
         scnt = 0;
      end else if (seq_req) begin
         if (scnt == LAT) begin
            seq_done   = 1'b1;
            seq_status = seq_wr_len;
            seq_rx_cnt = seq_rd_len;
            seq_tx_cnt = seq_wr_len + 8'd1;
         end else scnt++;
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = 8'(a);
      #1;
      chk(64'(reg_rdata), 64'(exp), tag);
   endtask

   task automatic put_desc(input int e, input logic [31:0] w0, input logic [31:0] w1);
      wr(128 + e*4, w0);
      wr(128 + e*4 + 1, w1);
      wr(128 + e*4 + 2, 32'h0000_1000 + 32'(e));
      wr(128 + e*4 + 3, 32'h0000_0000);
   endtask

   task automatic wait_idle;
      repeat (2) @(negedge clk);
      while (m_active) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk(2, 32'h0000_0000, "R1 control after reset");
      rd_chk(3, 32'h0000_0000, "R1 status after reset");
      rd_chk(4, 32'h0000_001F, "R1 size after reset");
      rd_chk(0, 32'h0000_0000, "R1 base low after reset");
      chk(64'(seq_req), 64'd0, "R1 seq_req after reset");
      chk(64'(irq), 64'd0, "R1 irq after reset");

      // R2 base address words
      wr(0, 32'hDEAD_BEEF);
      wr(1, 32'h0000_0012);
      rd_chk(0, 32'hDEAD_BEEF, "R2 base low");
      rd_chk(1, 32'h0000_0012, "R2 base high");

      // R3 descriptor window
      put_desc(0, 32'h0000_01A1, 32'h0000_5500);
      put_desc(1, 32'h4002_01B0, 32'h0000_0000);
      put_desc(2, 32'h0001_01C3, 32'h0000_0700);
      rd_chk(128 + 2, 32'h0000_1000, "R3 entry0 word2");
      rd_chk(128 + 8, 32'h0001_01C3, "R3 entry2 word0");

      // R4 start three descriptors
      wr(2, 32'h0003_0001);
      @(negedge clk);
      chk(64'(seq_req), 64'd1, "R4 seq_req after start");
      chk(64'(seq_target), 64'hA1, "R4 first target presented");
      rd_chk(3, 32'h0000_0001, "R4 busy with tail 0");
      wait_idle;
      rd_chk(3, 32'h0003_0020, "R5 R7 tail 3, done flag, idle");
      chk(64'(irq), 64'd1, "R10 irq from done flag");
      rd_chk(128 + 1, 32'h0200_5501, "R5 entry0 write-back keeps retry");
      rd_chk(128 + 5, 32'h0202_0001, "R5 entry1 write-back");
      rd_chk(128 + 9, 32'h0201_0701, "R5 entry2 write-back");

      // R8 write-one-to-clear
      wr(3, 32'h0000_0000);
      rd_chk(3, 32'h0003_0020, "R8 zero write leaves flag");
      wr(3, 32'h0000_0020);
      rd_chk(3, 32'h0003_0000, "R8 one clears done flag");
      chk(64'(irq), 64'd0, "R10 irq low after clear");

      // R6 ring size and wrap
      wr(4, 32'hFFFF_FFE3);
      rd_chk(4, 32'h0000_0003, "R6 size masked to index width");
      put_desc(3, 32'h0001_01D3, 32'h0000_0000);
      put_desc(0, 32'h0001_01D0, 32'h0000_0000);
      put_desc(1, 32'h4001_01D1, 32'h0000_0000);
      wr(2, 32'h0002_0001);
      wait_idle;
      rd_chk(3, 32'h0002_0020, "R6 tail wrapped to 2");
      rd_chk(128 + 1, 32'h0201_0001, "R6 wrapped entry0 written back");
      wr(3, 32'h0000_0020);

      // R9 stop on error, enable off
      put_desc(2, 32'h8000_08E2, 32'h0000_0000);
      put_desc(3, 32'h0000_01E3, 32'h0000_0000);
      wr(2, 32'h0000_0001);
      wait_idle;
      rd_chk(3, 32'h0003_0010, "R9 halted at tail 3 with error flag");
      rd_chk(2, 32'h0000_0000, "R9 run cleared by halt");
      rd_chk(128 + 9, 32'h0900_0008, "R9 faulted descriptor written back");
      chk(64'(irq), 64'd0, "R10 error flag masked");
      wr(2, 32'h0000_0010);
      repeat (3) @(negedge clk);
      chk(64'(irq), 64'd1, "R10 error flag with enable");
      chk(64'(seq_req), 64'd0, "R4 no request while run is 0");
      wr(3, 32'h0000_0010);
      rd_chk(3, 32'h0003_0000, "R8 one clears error flag");
      chk(64'(irq), 64'd0, "R10 irq low after error clear");

      // R9 fault without stop bit continues
      put_desc(3, 32'h0000_10E3, 32'h0000_0000);
      wr(2, 32'h0000_0011);
      wait_idle;
      rd_chk(3, 32'h0000_0000, "R9 fault without stop raises nothing");
      rd_chk(2, 32'h0000_0011, "R9 run kept");

      // R11 clear run mid-flight
      put_desc(0, 32'h0000_01F0, 32'h0000_0000);
      put_desc(1, 32'h0000_01F1, 32'h0000_0000);
      wr(2, 32'h0002_0011);
      wr(2, 32'h0002_0010);
      wait_idle;
      rd_chk(3, 32'h0001_0000, "R11 only the in-flight descriptor finished");
      rd_chk(128 + 1, 32'h0200_0001, "R11 in-flight descriptor written back");
      rd_chk(128 + 5, 32'h0000_0000, "R11 next descriptor untouched");

      repeat (4) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule